// File: doc/BRIEF.md
# Bank-Interleave Read Command Sequencer

This block produces a repeating stream of DRAM commands that walks a read access through four banks, one after another. Its purpose is to serve as a stimulus source for power or stress measurement. Each bank gets an activate. The read-with-auto-precharge for that bank follows in the very next clock, which works because the read is posted with an additive latency of tRCD minus one. A two-bit speed-grade input selects one of three timing profiles. Each profile sets how many deselect slots follow each activate/read pair and how many deselect slots pad the end of the loop, so that one loop lasts exactly tRC clocks.

Each clock, the sequencer drives one command code, a bank index and a valid strobe. It also reports the additive latency that belongs to the loop in progress. A start pulse begins looping. A stop request lets the current loop run to its end, after which the block goes idle. A one-cycle pulse marks the last slot of every loop, and a free-running counter counts the completed loops. The grade input is read only at a loop boundary.

Top module: `bank_interleave_seq`

## Requirements
- R1: Within one loop, banks are served in the order 0, 1, 2, 3. Each bank's activate is followed in the next clock by a read-with-auto-precharge to the same bank.
- R2: Command codes are 2'b00 for deselect, 2'b01 for activate and 2'b10 for read-with-auto-precharge. The bank index is 2 bits wide.
- R3: With grade 2'd0, a loop is 12 slots. Activates fall in slots 0, 2, 4 and 6, slots 8 to 11 are deselects, and the reported additive latency is 2.
- R4: With grade 2'd1, a loop is 16 slots. Activates fall in slots 0, 3, 6 and 9, every other non-read slot is a deselect, and the reported additive latency is 3.
- R5: With grade 2'd2 or 2'd3, a loop is 19 slots. Activates fall in slots 0, 4, 8 and 12, every other non-read slot is a deselect, and the reported additive latency is 3.
- R6: During a deselect slot, the bank output holds the value it had in the previous cycle.
- R7: A start pulse sampled while idle makes slot 0 (an activate to bank 0) appear in the next cycle. While a loop runs, cmd_valid is high. A start pulse during a loop has no effect.
- R8: The grade is sampled only when a loop begins. A change in the middle of a loop takes effect from the next loop.
- R9: A stop request lets the current loop finish, and the block is idle from the following cycle. While idle, idle is high, cmd_valid is low and the command is deselect. A stop request while idle has no effect.
- R10: loop_done is high for exactly the last slot of each loop, and loop_count is one higher in the cycle after that slot.
- R11: After reset: idle is 1, the command is deselect, cmd_valid is 0, bank is 0, loop_count is 0 and the additive latency is 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin looping when idle |
| stop | input | 1 | Finish current loop, then go idle |
| grade | input | 2 | Speed-grade select (0, 1, 2; 3 acts as 2) |
| cmd | output | 2 | Command code for this slot |
| bank | output | 2 | Bank index |
| cmd_valid | output | 1 | High in every slot of an active loop |
| add_lat | output | 2 | Additive latency of the running profile |
| idle | output | 1 | High when no loop is active |
| loop_done | output | 1 | High on the last slot of each loop |
| loop_count | output | 16 | Number of completed loops |

## Verification
All outputs come straight from state registers through decode logic only. A start or stop sampled at one rising edge therefore shows up on the outputs right after that edge. Inputs are driven at the falling edge, so an input set at one falling edge is taken at the next rising edge. The bench checks the outputs at the following falling edge: slot 0 one cycle after start, and idle one cycle after the final slot of a stopped loop. Within a loop, the bench checks slot s exactly s cycles after slot 0. loop_count is checked one cycle after loop_done.

// File: rtl/seq_pkg.sv
// Package: shared command codes and timing-profile type for the
// bank-interleave sequencer. Assumes at most 255 slots per loop.
package seq_pkg;
    localparam int TRC_W = 8;

    typedef enum logic [1:0] {
        CMD_DES = 2'b00,
        CMD_ACT = 2'b01,
        CMD_RDA = 2'b10
    } cmd_e;

    typedef struct packed {
        logic [TRC_W-1:0] trc;     // slots per loop
        logic [2:0]       period;  // slots per activate/read pair incl. gap
        logic [1:0]       al;      // posted additive latency
    } profile_t;
endpackage

// File: rtl/grade_profile.sv
// Module: grade_profile
// Decodes a speed-grade code into loop length, pair period and additive
// latency. Assumes the tail padding per grade (4, 4, 3 deselects) is tuned
// so that NUM_BANKS pairs plus padding equal tRC. Code 3 reuses grade 2.
module grade_profile #(
    parameter int NUM_BANKS = 4
) (
    input  logic [1:0]         grade_in,
    output seq_pkg::profile_t  prof
);
    import seq_pkg::*;

    // Purpose: select gap, tail and latency per grade, derive loop length.
    always_comb begin
        int gap;
        int tail;
        case (grade_in)
            2'd0:    begin gap = 0; tail = 4; prof.al = 2'd2; end
            2'd1:    begin gap = 1; tail = 4; prof.al = 2'd3; end
            default: begin gap = 2; tail = 3; prof.al = 2'd3; end
        endcase
        prof.period = 3'(gap + 2);
        prof.trc    = TRC_W'((gap + 2) * NUM_BANKS + tail);
    end
endmodule

// File: rtl/loop_ctrl.sv
// Module: loop_ctrl
// Runs the loop state: slot counter, position within the current pair,
// pair index, latched grade, pending stop and completed-loop counter.
// Assumes the profile input is decoded from cur_grade by the parent.
module loop_ctrl #(
    parameter int NUM_BANKS = 4,
    parameter int CNT_W     = 16,
    localparam int PAIR_W   = $clog2(NUM_BANKS + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic                      stop,
    input  logic [1:0]                grade_in,
    input  logic [seq_pkg::TRC_W-1:0] trc,
    input  logic [2:0]                period,
    output logic                      run,
    output logic                      last,
    output logic [2:0]                off,
    output logic [PAIR_W-1:0]         pair,
    output logic [1:0]                cur_grade,
    output logic [CNT_W-1:0]          loop_count
);
    import seq_pkg::*;

    logic [TRC_W-1:0] slot;
    logic             stop_pend;

    // Purpose: flag the final slot of the running loop.
    always_comb last = run && (slot == trc - 1'b1);

    // Purpose: advance slot/pair counters, handle start, stop and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run        <= 1'b0;
            slot       <= '0;
            off        <= '0;
            pair       <= '0;
            cur_grade  <= '0;
            stop_pend  <= 1'b0;
            loop_count <= '0;
        end else if (!run) begin
            stop_pend <= 1'b0;
            if (start) begin
                run       <= 1'b1;
                slot      <= '0;
                off       <= '0;
                pair      <= '0;
                cur_grade <= grade_in;
            end
        end else if (last) begin
            loop_count <= loop_count + 1'b1;
            slot       <= '0;
            off        <= '0;
            pair       <= '0;
            stop_pend  <= 1'b0;
            if (stop_pend || stop) run <= 1'b0;
            else                   cur_grade <= grade_in;
        end else begin
            if (stop) stop_pend <= 1'b1;
            slot <= slot + 1'b1;
            if (off == period - 1'b1) begin
                off <= '0;
                if (pair != PAIR_W'(NUM_BANKS)) pair <= pair + 1'b1;
            end else begin
                off <= off + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cmd_gen.sv
// Module: cmd_gen
// Turns loop position into a command code and bank index. Holds the bank
// output during deselect slots so address lines stay quiet. Assumes pair
// saturates at NUM_BANKS once the padding region is reached.
module cmd_gen #(
    parameter int NUM_BANKS = 4,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int PAIR_W   = $clog2(NUM_BANKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [2:0]        off,
    input  logic [PAIR_W-1:0] pair,
    output seq_pkg::cmd_e     cmd,
    output logic [BANK_W-1:0] bank
);
    import seq_pkg::*;

    logic              in_pair;
    logic [BANK_W-1:0] bank_q;

    // Purpose: decode activate / read / deselect for this slot.
    always_comb begin
        in_pair = run && (pair < PAIR_W'(NUM_BANKS));
        if (in_pair && off == 3'd0)      cmd = CMD_ACT;
        else if (in_pair && off == 3'd1) cmd = CMD_RDA;
        else                             cmd = CMD_DES;
    end

    // Purpose: remember the last bank driven with a real command.
    always_ff @(posedge clk) begin
        if (!rst_n)              bank_q <= '0;
        else if (cmd != CMD_DES) bank_q <= pair[BANK_W-1:0];
    end

    // Purpose: drive the live bank on commands, the held bank otherwise.
    always_comb bank = (cmd != CMD_DES) ? pair[BANK_W-1:0] : bank_q;
endmodule

// File: rtl/bank_interleave_seq.sv
// Module: bank_interleave_seq (top)
// Repeating activate/read-with-auto-precharge stream across the banks with
// per-grade spacing so one loop spans tRC clocks. Assumes start, stop and
// grade are synchronous to clk.
module bank_interleave_seq #(
    parameter int NUM_BANKS = 4,
    parameter int CNT_W     = 16,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int PAIR_W   = $clog2(NUM_BANKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stop,
    input  logic [1:0]        grade,
    output logic [1:0]        cmd,
    output logic [BANK_W-1:0] bank,
    output logic              cmd_valid,
    output logic [1:0]        add_lat,
    output logic              idle,
    output logic              loop_done,
    output logic [CNT_W-1:0]  loop_count
);
    import seq_pkg::*;

    profile_t          prof;
    logic              run;
    logic [2:0]        off;
    logic [PAIR_W-1:0] pair;
    logic [1:0]        cur_grade;
    cmd_e              cmd_int;

    grade_profile #(.NUM_BANKS(NUM_BANKS)) u_prof (
        .grade_in (cur_grade),
        .prof     (prof)
    );

    loop_ctrl #(.NUM_BANKS(NUM_BANKS), .CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .stop       (stop),
        .grade_in   (grade),
        .trc        (prof.trc),
        .period     (prof.period),
        .run        (run),
        .last       (loop_done),
        .off        (off),
        .pair       (pair),
        .cur_grade  (cur_grade),
        .loop_count (loop_count)
    );

    cmd_gen #(.NUM_BANKS(NUM_BANKS)) u_cmd (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .off   (off),
        .pair  (pair),
        .cmd   (cmd_int),
        .bank  (bank)
    );

    // Purpose: expose command, status and latency of the running profile.
    always_comb begin
        cmd       = cmd_int;
        cmd_valid = run;
        idle      = !run;
        add_lat   = prof.al;
    end
endmodule

// File: rtl/seq_checker.sv
// Module: seq_checker
// Protocol checks on the sequencer ports, bound into every instance.
module seq_checker #(
    parameter int BANK_W = 2,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [1:0]        cmd,
    input logic [BANK_W-1:0] bank,
    input logic              cmd_valid,
    input logic [1:0]        add_lat,
    input logic              idle,
    input logic              loop_done,
    input logic [CNT_W-1:0]  loop_count
);
    import seq_pkg::*;

    p_rda_after_act_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == CMD_ACT |=> cmd == CMD_RDA && bank == $past(bank));

    p_rda_needs_act_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == CMD_RDA |-> $past(cmd) == CMD_ACT);

    p_al_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        add_lat == 2'd2 || add_lat == 2'd3);

    p_bank_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_DES && $past(rst_n)) |-> $stable(bank));

    p_start_act0_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start) |=> cmd == CMD_ACT && bank == '0 && cmd_valid);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> cmd == CMD_DES && !cmd_valid && !loop_done);

    p_count_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        loop_done |=> loop_count == $past(loop_count) + 1'b1);

    p_count_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!loop_done && $past(rst_n)) |=> $stable(loop_count));
endmodule

bind bank_interleave_seq seq_checker #(.BANK_W(BANK_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cmd        (cmd),
    .bank       (bank),
    .cmd_valid  (cmd_valid),
    .add_lat    (add_lat),
    .idle       (idle),
    .loop_done  (loop_done),
    .loop_count (loop_count)
);

// File: tb/sim_bank_interleave_seq.sv
module sim_bank_interleave_seq;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;
    // grade, tRC, gap after pair, additive latency
    localparam int VEC [4][4] = '{'{0, 12, 0, 2}, '{1, 16, 1, 3},
                                  '{2, 19, 2, 3}, '{3, 19, 2, 3}};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        stop = 1'b0;
    logic [1:0]  grade = 2'd0;
    logic [1:0]  cmd;
    logic [1:0]  bank;
    logic        cmd_valid;
    logic [1:0]  add_lat;
    logic        idle;
    logic        loop_done;
    logic [15:0] loop_count;

    int checks = 0;
    int fails = 0;
    int exp_count = 0;
    int last_bank = 0;
    bit finished = 1'b0;

    bank_interleave_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .grade(grade),
        .cmd(cmd), .bank(bank), .cmd_valid(cmd_valid), .add_lat(add_lat),
        .idle(idle), .loop_done(loop_done), .loop_count(loop_count)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Checks one loop starting at slot 0 (already visible at this negedge).
    task automatic check_loop(input int g, input bit do_stop, input int chg_slot,
                              input int new_g, input bit poke_start);
        int trc = VEC[g][1];
        int per = VEC[g][2] + 2;
        string rg = (g == 0) ? "R3" : (g == 1) ? "R4" : "R5";
        for (int s = 0; s < trc; s++) begin
            int ec = 0;
            if (s < 4 * per) begin
                int o = s % per;
                if (o == 0) ec = 1;
                else if (o == 1) ec = 2;
                if (ec != 0) last_bank = s / per;
            end
            chk($sformatf("%s/R2/R1 slot %0d cmd", rg, s), cmd, ec);
            chk($sformatf("%s slot %0d bank (R6 when deselect)", rg, s), bank, last_bank);
            chk($sformatf("R7 slot %0d cmd_valid", s), cmd_valid, 1);
            chk($sformatf("R9 slot %0d idle", s), idle, 0);
            chk($sformatf("R10 slot %0d loop_done", s), loop_done, (s == trc - 1) ? 1 : 0);
            chk($sformatf("%s/R8 slot %0d add_lat", rg, s), add_lat, VEC[g][3]);
            if (s == 0) chk("R10 count at loop start", loop_count, exp_count);
            stop  = (do_stop && s == 1);
            start = (poke_start && s == 2);
            if (s == chg_slot) grade = 2'(new_g);
            @(negedge clk);
        end
        stop = 1'b0;
        start = 1'b0;
        exp_count++;
        chk("R10 count after loop_done", loop_count, exp_count);
    endtask

    task automatic check_idle(input string tag);
        chk({tag, " idle"}, idle, 1);
        chk({tag, " cmd"}, cmd, 0);
        chk({tag, " cmd_valid"}, cmd_valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 idle", idle, 1);
        chk("R11 cmd", cmd, 0);
        chk("R11 cmd_valid", cmd_valid, 0);
        chk("R11 bank", bank, 0);
        chk("R11 loop_count", loop_count, 0);
        chk("R11 add_lat", add_lat, 2);

        // R9: stop while idle is ignored
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        @(negedge clk);
        check_idle("R9 stop-in-idle");

        // Table walk: each grade, one loop, stop mid-loop, start poke ignored (R7)
        for (int v = 0; v < 4; v++) begin
            grade = 2'(VEC[v][0]);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check_loop(v, 1'b1, -1, 0, 1'b1);
            check_idle("R9 after stopped loop");
            @(negedge clk);
            check_idle("R9 stays idle");
        end

        // R8: grade changes mid-loop, new grade from next loop only
        grade = 2'd0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check_loop(0, 1'b0, 3, 2, 1'b0);
        check_loop(2, 1'b0, 5, 1, 1'b0);
        check_loop(1, 1'b1, -1, 0, 1'b0);
        check_idle("R9 after back-to-back loops");

        // R11: reset mid-loop returns to the reset state
        grade = 2'd2;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R11 reset mid-loop idle", idle, 1);
        chk("R11 reset mid-loop bank", bank, 0);
        chk("R11 reset mid-loop count", loop_count, 0);
        chk("R11 reset mid-loop add_lat", add_lat, 2);

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=0", WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule